// File: doc/BRIEF.md
# Lockable Programmable Clock Divider

This block holds one 8-bit configuration register that a host writes and reads back over a simple parallel bus. The register sets a divider that turns a reference clock into a slower high-frequency output, with one of eight ratios picked by a non-linear 3-bit code. Divide-by-one passes the reference clock straight through. A disable bit stops the divider and holds its output low to save power. A second field picks which of two slow clock enables drives the low-frequency output. Two read-only fields report a strap that is sampled at standby reset and whether the internal clock is running.

The register can protect itself. Writing a 1 to its top bit freezes every field, and that bit cannot be written back to 0. The lock is released by an unlock pulse or by a standby reset. A main-domain reset also releases it when a configuration input selects that option. The divider only picks up a new ratio at the start of a low phase, so a high phase that is already running always finishes at the old length.

The design has two state machines. The lock machine has the states LK_OPEN and LK_SHUT. It takes the transitions set-by-write (OPEN to SHUT), release-by-unlock and release-by-reset (SHUT to OPEN). The divider machine has the states ST_OFF, ST_LOW, ST_HIGH and ST_PASS. Its transitions are enable (OFF to LOW or PASS), phase-end (LOW to HIGH, and HIGH to LOW or PASS), leave-pass (PASS to LOW when the code becomes non-zero) and disable (any state to OFF).

Top module: `hfdiv_top`

## Requirements
- R1: After a standby reset, `rd_data` reads lock=0 (bit 7), low-frequency select=0 (bit 6), disable=0 (bit 5), and the divide code (bits 2:0) is 000 if `strap` was 1 during reset, or 001 if it was 0.
- R2: Writing a 1 to bit 7 sets the lock. While the lock is set, any `wr_en` cycle changes no field, including bit 7 itself, and causes no error.
- R3: The lock clears in three cases: one cycle after `unlock` is high, during any standby reset, or during a main reset (`rst_main_n` low) when `lock_by_sb` is 0. When `lock_by_sb` is 1, a main reset leaves the lock and all fields unchanged.
- R4: Bit 3 returns the value of `strap` sampled during the last standby reset. It ignores later changes on `strap` and ignores writes.
- R5: Bit 4 reads the current value of `clk_ok` and ignores writes.
- R6: The divide code in bits 2:0 maps to these ratios: 000=1, 001=2, 010=3, 011=4, 100=6, 101=8, 110=12, 111=16. For a ratio N of 2 or more, the output is high for floor(N/2) reference cycles and low for the rest, so even ratios give a 50% duty cycle.
- R7: With code 000 and disable=0, `hf_out` follows `clk`: high during the high half of each reference cycle and low during the low half.
- R8: Two reference cycles after the disable bit (bit 5) is written to 1, `hf_out` stays low.
- R9: `lf_out` equals `lf_fast_en` when bit 6 is 0 and `lf_slow_en` when bit 6 is 1.
- R10: A change of divide code never shortens a high phase that is already running. The new ratio starts with the next low phase.
- R11: An unlocked write stores bit 7 (set only), bit 6, bit 5 and bits 2:0, and `rd_data` returns the current contents in the same layout on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the register and the divider both run on it |
| rst_sb_n | input | 1 | Standby-domain reset, active low, synchronous |
| rst_main_n | input | 1 | Main-domain reset, active low, synchronous |
| lock_by_sb | input | 1 | 1: only a standby reset clears the lock; 0: a main reset clears it as well |
| unlock | input | 1 | Pulse that clears the lock |
| strap | input | 1 | Strap level, captured during standby reset |
| clk_ok | input | 1 | Internal clock is active and stable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| lf_fast_en | input | 1 | Fast slow-clock source (32.768 kHz enable) |
| lf_slow_en | input | 1 | Slow source (1 Hz enable) |
| lf_out | output | 1 | Selected low-frequency output |
| hf_out | output | 1 | Divided high-frequency output |

## Verification
Assertions check on every cycle that a locked register holds its writable fields against writes. They also check that an unlock pulse, or a main reset with `lock_by_sb` at 0, clears the lock. The strap field must stay fixed between standby resets, and a disable held for two cycles must keep `hf_out` low. The bench scenarios cover the rest: the duty cycle and period for each of the eight codes, pass-through of the reference clock at the phase level, and a code change in the middle of a high phase that must complete at its old length. They also cover both strap reset values, low-frequency source selection, and a main reset that must keep the lock when `lock_by_sb` is 1.

// File: rtl/hfdiv_pkg.sv
package hfdiv_pkg;
    localparam int CODE_W    = 3;
    localparam int REG_W     = 8;
    localparam int MAX_RATIO = 16;
    localparam int RATIO_W   = $clog2(MAX_RATIO) + 1;
    localparam int LEN_W     = $clog2(MAX_RATIO / 2) + 1;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_LOW,
        ST_HIGH,
        ST_PASS
    } div_state_e;

    typedef enum logic {
        LK_OPEN,
        LK_SHUT
    } lock_state_e;

    // Non-linear code-to-ratio map
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'd0: r = RATIO_W'(1);
            3'd1: r = RATIO_W'(2);
            3'd2: r = RATIO_W'(3);
            3'd3: r = RATIO_W'(4);
            3'd4: r = RATIO_W'(6);
            3'd5: r = RATIO_W'(8);
            3'd6: r = RATIO_W'(12);
            default: r = RATIO_W'(16);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/hfdiv_cfg_reg.sv
module hfdiv_cfg_reg
    import hfdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_sb_n,
    input  logic              rst_main_n,
    input  logic              lock_by_sb,
    input  logic              unlock,
    input  logic              strap,
    input  logic              clk_ok,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              lf_sel,
    output logic              hf_dis,
    output logic [CODE_W-1:0] div_code
);
    lock_state_e       lock_q, lock_n;
    logic              strap_q;
    logic              lf_q, dis_q;
    logic [CODE_W-1:0] code_q;
    logic              wr_ok;

    assign wr_ok = wr_en && rst_main_n && !unlock && (lock_q == LK_OPEN);

    // Lock machine: next state
    always_comb begin
        lock_n = lock_q;
        unique case (lock_q)
            LK_OPEN: if (wr_ok && wr_data[REG_W-1]) lock_n = LK_SHUT;   // set-by-write
            LK_SHUT: begin
                if (!rst_main_n && !lock_by_sb) lock_n = LK_OPEN;        // release-by-reset
                else if (rst_main_n && unlock)  lock_n = LK_OPEN;        // release-by-unlock
            end
        endcase
    end

    // Lock machine: state register
    always_ff @(posedge clk) begin
        if (!rst_sb_n) lock_q <= LK_OPEN;
        else           lock_q <= lock_n;
    end

    // Fields
    always_ff @(posedge clk) begin
        if (!rst_sb_n) begin
            strap_q <= strap;
            lf_q    <= 1'b0;
            dis_q   <= 1'b0;
            code_q  <= strap ? CODE_W'(0) : CODE_W'(1);
        end else if (wr_ok) begin
            lf_q    <= wr_data[6];
            dis_q   <= wr_data[5];
            code_q  <= wr_data[CODE_W-1:0];
        end
    end

    assign rd_data  = {(lock_q == LK_SHUT), lf_q, dis_q, clk_ok, strap_q, code_q};
    assign lf_sel   = lf_q;
    assign hf_dis   = dis_q;
    assign div_code = code_q;
endmodule

// File: rtl/hfdiv_core.sv
module hfdiv_core
    import hfdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hf_dis,
    input  logic [CODE_W-1:0] div_code,
    output logic              hf_out
);
    div_state_e         state_q, state_n;
    logic [LEN_W-1:0]   cnt_q;
    logic [CODE_W-1:0]  act_q;
    logic [RATIO_W-1:0] ratio, half;
    logic [LEN_W-1:0]   hi_len, lo_len, cur_len;
    logic               phase_done, want_pass;
    logic               div_q, gate_q;

    always_comb begin
        ratio      = ratio_of(act_q);
        half       = ratio >> 1;
        hi_len     = half[LEN_W-1:0];
        lo_len     = LEN_W'(ratio - half);
        cur_len    = (state_q == ST_HIGH) ? hi_len : lo_len;
        phase_done = (cnt_q == cur_len - LEN_W'(1));
        want_pass  = (div_code == '0);
    end

    // Divider machine: next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF:  if (!hf_dis) state_n = want_pass ? ST_PASS : ST_LOW;          // enable
            ST_LOW: begin
                if (hf_dis)          state_n = ST_OFF;                             // disable
                else if (phase_done) state_n = ST_HIGH;                            // phase-end
            end
            ST_HIGH: begin
                if (hf_dis)          state_n = ST_OFF;                             // disable
                else if (phase_done) state_n = want_pass ? ST_PASS : ST_LOW;       // phase-end
            end
            ST_PASS: begin
                if (hf_dis)          state_n = ST_OFF;                             // disable
                else if (!want_pass) state_n = ST_LOW;                             // leave-pass
            end
        endcase
    end

    // Divider machine: state register, phase counter and ratio capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            act_q   <= CODE_W'(1);
        end else begin
            state_q <= state_n;
            if (state_n != state_q) cnt_q <= '0;
            else                    cnt_q <= cnt_q + LEN_W'(1);
            if (state_n == ST_LOW && state_q != ST_LOW) act_q <= div_code;
        end
    end

    // Outputs: registered divided level and a low-phase clock gate for pass-through
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= (state_n == ST_HIGH);
    end

    always_ff @(negedge clk) begin
        gate_q <= rst_n && (state_q == ST_PASS);
    end

    assign hf_out = div_q | (clk & gate_q);
endmodule

// File: rtl/hfdiv_top.sv
module hfdiv_top
    import hfdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_sb_n,
    input  logic             rst_main_n,
    input  logic             lock_by_sb,
    input  logic             unlock,
    input  logic             strap,
    input  logic             clk_ok,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             lf_fast_en,
    input  logic             lf_slow_en,
    output logic             lf_out,
    output logic             hf_out
);
    logic              lf_sel, hf_dis;
    logic [CODE_W-1:0] div_code;

    hfdiv_cfg_reg u_reg (
        .clk        (clk),
        .rst_sb_n   (rst_sb_n),
        .rst_main_n (rst_main_n),
        .lock_by_sb (lock_by_sb),
        .unlock     (unlock),
        .strap      (strap),
        .clk_ok     (clk_ok),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .lf_sel     (lf_sel),
        .hf_dis     (hf_dis),
        .div_code   (div_code)
    );

    hfdiv_core u_core (
        .clk      (clk),
        .rst_n    (rst_sb_n & rst_main_n),
        .hf_dis   (hf_dis),
        .div_code (div_code),
        .hf_out   (hf_out)
    );

    assign lf_out = lf_sel ? lf_slow_en : lf_fast_en;
endmodule

// File: rtl/hfdiv_checker.sv
module hfdiv_checker (
    input logic       clk,
    input logic       rst_sb_n,
    input logic       rst_main_n,
    input logic       lock_by_sb,
    input logic       unlock,
    input logic [7:0] rd_data,
    input logic       hf_out
);
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_sb_n)
        rst_sb_n && rd_data[7] && rst_main_n && !unlock
        |=> {rd_data[7:5], rd_data[2:0]} == $past({rd_data[7:5], rd_data[2:0]})); // R2

    AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sb_n)
        rst_sb_n && rst_main_n && unlock |=> !rd_data[7]); // R3

    AST_MAIN_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_sb_n)
        rst_sb_n && !rst_main_n && !lock_by_sb |=> !rd_data[7]); // R3

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_sb_n)
        rst_sb_n |=> $stable(rd_data[3])); // R4

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_sb_n || !rst_main_n)
        rd_data[5] && $past(rd_data[5]) |-> !hf_out); // R8
endmodule

bind hfdiv_top hfdiv_checker u_chk (
    .clk        (clk),
    .rst_sb_n   (rst_sb_n),
    .rst_main_n (rst_main_n),
    .lock_by_sb (lock_by_sb),
    .unlock     (unlock),
    .rd_data    (rd_data),
    .hf_out     (hf_out)
);

// File: tb/hfdiv_top_test.sv
module hfdiv_top_test;
    logic       clk = 1'b0;
    logic       rst_sb_n, rst_main_n, lock_by_sb, unlock, strap, clk_ok;
    logic       wr_en, lf_fast_en, lf_slow_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       lf_out, hf_out;
    int         tests = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    hfdiv_top uut (
        .clk(clk), .rst_sb_n(rst_sb_n), .rst_main_n(rst_main_n), .lock_by_sb(lock_by_sb),
        .unlock(unlock), .strap(strap), .clk_ok(clk_ok), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .lf_fast_en(lf_fast_en), .lf_slow_en(lf_slow_en),
        .lf_out(lf_out), .hf_out(hf_out)
    );

    typedef struct packed {
        logic [2:0] code;
        logic [7:0] highs;
        logic [7:0] rises;
    } vec_t;

    // Over 48 samples: highs = 48/N*floor(N/2) (48 for pass), rises = 48/N (0 for pass)
    localparam vec_t VECS [0:7] = '{
        '{3'd0, 8'd48, 8'd0},  '{3'd1, 8'd24, 8'd24},
        '{3'd2, 8'd16, 8'd16}, '{3'd3, 8'd24, 8'd12},
        '{3'd4, 8'd24, 8'd8},  '{3'd5, 8'd24, 8'd6},
        '{3'd6, 8'd24, 8'd4},  '{3'd7, 8'd24, 8'd3}
    };

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic bus_write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic measure(output int highs, output int rises);
        logic prev;
        highs = 0;
        rises = 0;
        prev = hf_out;
        for (int i = 0; i < 48; i++) begin
            tick();
            if (hf_out) highs++;
            if (hf_out && !prev) rises++;
            prev = hf_out;
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int h, r, run;
        logic prev;
        rst_sb_n = 0; rst_main_n = 0; lock_by_sb = 0; unlock = 0; strap = 0; clk_ok = 1;
        wr_en = 0; wr_data = 0; lf_fast_en = 1; lf_slow_en = 0;
        repeat (3) tick();
        rst_sb_n = 1; rst_main_n = 1;
        tick();

        check("R1 reset strap0", rd_data, 8'h11);
        strap = 1; tick();
        check("R4 strap change ignored", rd_data[3], 0);
        bus_write(8'h08);
        check("R4 write to strap bit ignored", rd_data, 8'h10);
        clk_ok = 0; tick();
        check("R5 clk_ok low", rd_data, 8'h00);
        clk_ok = 1; tick();
        check("R5 clk_ok high", rd_data[4], 1);

        check("R9 fast source", lf_out, 1);
        bus_write(8'h40);
        check("R9 slow source sel", lf_out, 0);
        lf_fast_en = 0; lf_slow_en = 1; #1;
        check("R9 slow source high", lf_out, 1);
        bus_write(8'h01);
        check("R9 back to fast", lf_out, 0);
        check("R11 readback", rd_data, 8'h11);

        foreach (VECS[i]) begin
            bus_write({5'b0, VECS[i].code});
            check("R11 code readback", rd_data, {5'b00010, VECS[i].code});
            repeat (40) tick();
            measure(h, r);
            check(VECS[i].code == 3'd0 ? "R7 pass highs" : "R6 highs", h, VECS[i].highs);
            check(VECS[i].code == 3'd0 ? "R7 pass rises" : "R6 rises", r, VECS[i].rises);
            if (VECS[i].code == 3'd0) begin
                @(negedge clk); #5;
                check("R7 pass low half", hf_out, 0);
                tick();
            end
        end

        // R10: change code in the middle of a divide-by-16 high phase
        bus_write(8'h07);
        repeat (40) tick();
        prev = hf_out;
        for (int k = 0; k < 40 && !(hf_out && !prev); k++) begin
            prev = hf_out;
            tick();
        end
        run = 1;
        bus_write(8'h01);
        if (hf_out) run++;
        for (int k = 0; k < 20 && hf_out; k++) begin
            tick();
            if (hf_out) run++;
        end
        check("R10 high phase kept", run, 8);
        tick();
        check("R10 new low phase", hf_out, 1);
        tick();
        check("R10 new high phase", hf_out, 0);

        bus_write(8'h25);
        check("R8 readback", rd_data, 8'h35);
        tick();
        measure(h, r);
        check("R8 disabled highs", h, 0);

        bus_write(8'h82);
        check("R2 lock set", rd_data, 8'h92);
        bus_write(8'h45);
        check("R2 write ignored", rd_data, 8'h92);
        bus_write(8'h00);
        check("R2 lock not cleared", rd_data, 8'h92);
        repeat (10) tick();
        measure(h, r);
        check("R2 divider unchanged", h, 16);

        unlock = 1; tick(); unlock = 0;
        check("R3 unlock", rd_data, 8'h12);
        bus_write(8'h00);
        check("R3 write accepted", rd_data, 8'h10);
        bus_write(8'h80);
        lock_by_sb = 1; rst_main_n = 0; tick(); tick(); rst_main_n = 1; tick();
        check("R3 main reset kept lock", rd_data, 8'h90);
        lock_by_sb = 0; rst_main_n = 0; tick(); tick(); rst_main_n = 1; tick();
        check("R3 main reset cleared lock", rd_data, 8'h10);

        rst_sb_n = 0; strap = 1; tick(); tick(); rst_sb_n = 1; tick();
        check("R1 reset strap1", rd_data, 8'h18);

        done = 1'b1;
        finish_run();
    end
endmodule